// File: doc/BRIEF.md
# PCI DMA Window Address Translator

This block turns the bus address of an incoming PCI DMA request into a host-side result. It holds four programmable translation windows and a global control word, all set through a small register port. Each window has a base, a size mask and a translated base. A window works either as a direct map, which gives the host page and its offset mask, or in scatter-gather mode, which gives the address of the page-table entry the system must fetch next.

Requests below 4 GiB are single-address cycles. For these, windows 0, 1 and 2 are tried in that order, and then window 3. A control bit can reserve a legacy hole in which every request misses. Requests above 4 GiB are dual-address cycles. They can hit a flat large window that maps a fixed range straight onto host address zero. They can also hit window 3 when that window is switched to dual-address use. The entry fetch and error reporting are left to the blocks around this one.

Every request is answered one cycle later with a result kind, an address and a mask.

Top module: `dma_xlat`

## Requirements
- R1: Register reads return the stored value of the addressed register. Offsets that map to no register read as zero, and writes to them change nothing. Registers sit at 64-byte steps: group {base 0x000, mask 0x100, translated base 0x200, control 0x300}, plus window × 0x40.
- R2: A base write for windows 0–2 keeps only bits 31:20 and 1:0. Bit 0 enables the window and bit 1 selects scatter-gather mode. A cleared bit 0 makes the window never hit.
- R3: A base write for window 3 keeps bits 40, 31:20 and 0. Bit 1 always reads as 1, and the register resets to 2.
- R4: A mask write keeps bits 31:20 only. A translated-base write keeps bits 34:10 only. A control write changes only the bits set in 0x00001CFF0FC7FF. All registers other than window 3's base reset to 0.
- R5: When req_valid is seen at a clock edge, rsp_valid is high after the next edge, and it is low otherwise. rsp_kind is encoded as 0 miss, 1 direct, 2 scatter-gather and 3 flat.
- R6: A window hits when it is enabled and (addr & ~(mask | 0xFFFFF)) equals (base & 0xFFF00000).
- R7: A direct-mode hit returns tba & ~ext as rsp_addr and ext as rsp_mask, where ext = mask | 0xFFFFF.
- R8: A scatter-gather hit on a single-address cycle returns (tba & ~(mask >> 10)) | ((addr & (mask | 0xFE000)) >> 10) as rsp_addr, with rsp_mask 0.
- R9: In a single-address cycle (addr < 2^32), the lowest-numbered hitting window wins. Window 3 takes part only while its bit 40 is clear.
- R10: While control bit 5 is set, single-address requests from 0x80000 to 0xFFFFF always miss.
- R11: While control bit 6 is set, dual-address requests from 0x100_0000_0000 to 0x1FF_FFFF_FFFF return kind flat, with rsp_addr 0 and rsp_mask 0x7_FFFF_FFFF. Single-address requests never return flat.
- R12: A dual-address request from 0x800_0000_0000 to 0xFFF_FFFF_FFFF, with window 3 bits 40 and 0 both set, returns scatter-gather with rsp_addr (tba3 & 0x7FFC00000) | ((addr & 0xFFFFE000) >> 10).
- R13: A miss returns rsp_addr 0 and rsp_mask 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 10 | Register byte offset |
| reg_wdata | input | 64 | Register write data |
| reg_rdata | output | 64 | Read data for reg_addr (combinational) |
| req_valid | input | 1 | Translation request strobe |
| req_addr | input | 44 | PCI bus address to translate |
| rsp_valid | output | 1 | Result valid, one cycle after the request |
| rsp_kind | output | 2 | 0 miss, 1 direct, 2 scatter-gather, 3 flat |
| rsp_addr | output | 44 | Host page, entry address or zero |
| rsp_mask | output | 44 | Offset mask of the result |

## Verification
Some properties hold on every cycle, and the assertions check these. The response follows the request by exactly one cycle. The hole always misses while it is enabled. A flat result always has its fixed shape, and a single-address request never returns flat. Misses carry zero fields, direct results are page aligned with an offset mask of at least 20 bits, and window 3's mode bit always reads as set.

The scenarios in the bench cover what needs a programmed context. That means window priority when windows overlap, the exact entry addresses, the hole and flat-window edges, window 3 moving from single-address to dual-address use, and the masking of each register on write.

// File: rtl/dma_xlat_pkg.sv
package dma_xlat_pkg;

    localparam int REG_W   = 64;
    localparam int XA_W    = 44;
    localparam int NUM_WIN = 4;
    localparam int OFS_W   = 10;
    localparam int WIN_W   = $clog2(NUM_WIN);
    localparam int SAC_W   = 32;

    typedef enum logic [1:0] {
        XK_MISS   = 2'd0,
        XK_DIRECT = 2'd1,
        XK_SG     = 2'd2,
        XK_FLAT   = 2'd3
    } xlat_kind_e;

    typedef struct packed {
        xlat_kind_e        kind;
        logic [XA_W-1:0]   addr;
        logic [XA_W-1:0]   mask;
    } xlat_rsp_t;

    typedef enum logic [1:0] {
        GRP_BASE = 2'd0,
        GRP_MASK = 2'd1,
        GRP_TBA  = 2'd2,
        GRP_CTL  = 2'd3
    } reg_grp_e;

    // write keep masks
    localparam logic [REG_W-1:0] BASE_KEEP   = 64'h0000_0000_FFF0_0003;
    localparam logic [REG_W-1:0] BASE3_KEEP  = 64'h0000_0100_FFF0_0001;
    localparam logic [REG_W-1:0] BASE3_FORCE = 64'h0000_0000_0000_0002;
    localparam logic [REG_W-1:0] MASK_KEEP   = 64'h0000_0000_FFF0_0000;
    localparam logic [REG_W-1:0] TBA_KEEP    = 64'h0000_0007_FFFF_FC00;
    localparam logic [REG_W-1:0] CTL_KEEP    = 64'h0000_1CFF_0FC7_FF;

    // match and translation constants
    localparam logic [REG_W-1:0] PAGE_OFS    = 64'h0000_0000_000F_FFFF;
    localparam logic [REG_W-1:0] BASE_CMP    = 64'h0000_0000_FFF0_0000;
    localparam logic [REG_W-1:0] SG_IDX      = 64'h0000_0000_000F_E000;
    localparam logic [REG_W-1:0] DAC_TBA     = 64'h0000_0007_FFC0_0000;
    localparam logic [REG_W-1:0] DAC_IDX     = 64'h0000_0000_FFFF_E000;
    localparam int               IDX_SHIFT   = 10;

    localparam logic [XA_W-1:0]  HOLE_LO     = 44'h000_0008_0000;
    localparam logic [XA_W-1:0]  HOLE_HI     = 44'h000_000F_FFFF;
    localparam logic [XA_W-1:0]  FLAT_LO     = 44'h100_0000_0000;
    localparam logic [XA_W-1:0]  FLAT_HI     = 44'h1FF_FFFF_FFFF;
    localparam logic [XA_W-1:0]  FLAT_MASK   = 44'h007_FFFF_FFFF;
    localparam logic [XA_W-1:0]  DAC3_LO     = 44'h800_0000_0000;

    localparam int CTL_HOLE_BIT = 5;
    localparam int CTL_FLAT_BIT = 6;
    localparam int DAC_EN_BIT   = 40;
    localparam int WIN_EN_BIT   = 0;
    localparam int WIN_SG_BIT   = 1;

    function automatic xlat_rsp_t make_rsp(xlat_kind_e k,
                                           logic [REG_W-1:0] a,
                                           logic [REG_W-1:0] m);
        xlat_rsp_t r;
        r.kind = k;
        r.addr = a[XA_W-1:0];
        r.mask = m[XA_W-1:0];
        return r;
    endfunction

endpackage

// File: rtl/dma_xlat_regs.sv
module dma_xlat_regs
    import dma_xlat_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [OFS_W-1:0] ofs,
    input  logic [REG_W-1:0] wdata,
    output logic [REG_W-1:0] rdata,
    output logic [REG_W-1:0] base_q [NUM_WIN],
    output logic [REG_W-1:0] mask_q [NUM_WIN],
    output logic [REG_W-1:0] tba_q  [NUM_WIN],
    output logic             ctl_hole,
    output logic             ctl_flat
);

    localparam int LAST = NUM_WIN - 1;

    logic [REG_W-1:0] ctl_q;
    reg_grp_e         grp;
    logic [WIN_W-1:0] win;
    logic             aligned;

    assign grp     = reg_grp_e'(ofs[OFS_W-1 -: 2]);
    assign win     = ofs[OFS_W-3 -: WIN_W];
    assign aligned = (ofs[OFS_W-3-WIN_W:0] == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NUM_WIN; i++) begin
                base_q[i] <= (i == LAST) ? BASE3_FORCE : '0;
                mask_q[i] <= '0;
                tba_q[i]  <= '0;
            end
            ctl_q <= '0;
        end else if (wr_en && aligned) begin
            unique case (grp)
                GRP_BASE: begin
                    if (int'(win) == LAST)
                        base_q[win] <= (wdata & BASE3_KEEP) | BASE3_FORCE;
                    else
                        base_q[win] <= wdata & BASE_KEEP;
                end
                GRP_MASK: mask_q[win] <= wdata & MASK_KEEP;
                GRP_TBA:  tba_q[win]  <= wdata & TBA_KEEP;
                GRP_CTL: begin
                    if (win == '0)
                        ctl_q <= (ctl_q & ~CTL_KEEP) | (wdata & CTL_KEEP);
                end
                default: ;
            endcase
        end
    end

    always_comb begin
        rdata = '0;
        if (aligned) begin
            unique case (grp)
                GRP_BASE: rdata = base_q[win];
                GRP_MASK: rdata = mask_q[win];
                GRP_TBA:  rdata = tba_q[win];
                GRP_CTL:  rdata = (win == '0) ? ctl_q : '0;
                default:  rdata = '0;
            endcase
        end
    end

    assign ctl_hole = ctl_q[CTL_HOLE_BIT];
    assign ctl_flat = ctl_q[CTL_FLAT_BIT];

endmodule

// File: rtl/dma_xlat_win.sv
module dma_xlat_win
    import dma_xlat_pkg::*;
(
    input  logic [REG_W-1:0] base,
    input  logic [REG_W-1:0] mask,
    input  logic [REG_W-1:0] tba,
    input  logic [REG_W-1:0] addr,
    output logic             hit,
    output logic             sg,
    output logic [REG_W-1:0] page,
    output logic [REG_W-1:0] ext,
    output logic [REG_W-1:0] pte
);

    assign ext  = mask | PAGE_OFS;
    assign hit  = base[WIN_EN_BIT] && ((addr & ~ext) == (base & BASE_CMP));
    assign sg   = base[WIN_SG_BIT];
    assign page = tba & ~ext;
    assign pte  = (tba & ~(mask >> IDX_SHIFT))
                | ((addr & (mask | SG_IDX)) >> IDX_SHIFT);

endmodule

// File: rtl/dma_xlat.sv
module dma_xlat
    import dma_xlat_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             reg_we,
    input  logic [OFS_W-1:0] reg_addr,
    input  logic [REG_W-1:0] reg_wdata,
    output logic [REG_W-1:0] reg_rdata,
    input  logic             req_valid,
    input  logic [XA_W-1:0]  req_addr,
    output logic             rsp_valid,
    output logic [1:0]       rsp_kind,
    output logic [XA_W-1:0]  rsp_addr,
    output logic [XA_W-1:0]  rsp_mask
);

    localparam int LAST = NUM_WIN - 1;

    logic [REG_W-1:0] base_q [NUM_WIN];
    logic [REG_W-1:0] mask_q [NUM_WIN];
    logic [REG_W-1:0] tba_q  [NUM_WIN];
    logic             ctl_hole;
    logic             ctl_flat;

    dma_xlat_regs u_regs (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (reg_we),
        .ofs      (reg_addr),
        .wdata    (reg_wdata),
        .rdata    (reg_rdata),
        .base_q   (base_q),
        .mask_q   (mask_q),
        .tba_q    (tba_q),
        .ctl_hole (ctl_hole),
        .ctl_flat (ctl_flat)
    );

    logic [REG_W-1:0] addr_x;
    assign addr_x = {{(REG_W-XA_W){1'b0}}, req_addr};

    logic [NUM_WIN-1:0] win_hit;
    logic [NUM_WIN-1:0] win_sg;
    logic [NUM_WIN-1:0] win_ok;
    logic [REG_W-1:0]   win_page [NUM_WIN];
    logic [REG_W-1:0]   win_ext  [NUM_WIN];
    logic [REG_W-1:0]   win_pte  [NUM_WIN];

    for (genvar g = 0; g < NUM_WIN; g++) begin : g_win
        dma_xlat_win u_win (
            .base (base_q[g]),
            .mask (mask_q[g]),
            .tba  (tba_q[g]),
            .addr (addr_x),
            .hit  (win_hit[g]),
            .sg   (win_sg[g]),
            .page (win_page[g]),
            .ext  (win_ext[g]),
            .pte  (win_pte[g])
        );
        if (g == LAST) begin : g_last
            assign win_ok[g] = win_hit[g] && !base_q[g][DAC_EN_BIT];
        end else begin : g_low
            assign win_ok[g] = win_hit[g];
        end
    end

    logic is_sac, in_hole, in_flat, in_dac3, dac3_on;
    logic [REG_W-1:0] dac_pte;

    assign is_sac  = (req_addr[XA_W-1:SAC_W] == '0);
    assign in_hole = ctl_hole && (req_addr >= HOLE_LO) && (req_addr <= HOLE_HI);
    assign in_flat = ctl_flat && (req_addr >= FLAT_LO) && (req_addr <= FLAT_HI);
    assign in_dac3 = (req_addr >= DAC3_LO);
    assign dac3_on = base_q[LAST][DAC_EN_BIT] && base_q[LAST][WIN_EN_BIT];
    assign dac_pte = (tba_q[LAST] & DAC_TBA) | ((addr_x & DAC_IDX) >> IDX_SHIFT);

    xlat_rsp_t nxt;

    always_comb begin
        nxt = make_rsp(XK_MISS, '0, '0);
        if (is_sac) begin
            if (!in_hole) begin
                for (int i = LAST; i >= 0; i--) begin
                    if (win_ok[i]) begin
                        if (win_sg[i])
                            nxt = make_rsp(XK_SG, win_pte[i], '0);
                        else
                            nxt = make_rsp(XK_DIRECT, win_page[i], win_ext[i]);
                    end
                end
            end
        end else if (in_flat) begin
            nxt = make_rsp(XK_FLAT, '0, {{(REG_W-XA_W){1'b0}}, FLAT_MASK});
        end else if (in_dac3 && dac3_on) begin
            nxt = make_rsp(XK_SG, dac_pte, '0);
        end
    end

    xlat_rsp_t rsp_q;
    logic      vld_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            vld_q <= 1'b0;
            rsp_q <= make_rsp(XK_MISS, '0, '0);
        end else begin
            vld_q <= req_valid;
            if (req_valid)
                rsp_q <= nxt;
        end
    end

    assign rsp_valid = vld_q;
    assign rsp_kind  = rsp_q.kind;
    assign rsp_addr  = rsp_q.addr;
    assign rsp_mask  = rsp_q.mask;

endmodule

// File: rtl/dma_xlat_chk.sv
module dma_xlat_chk
    import dma_xlat_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic [OFS_W-1:0] reg_addr,
    input logic [REG_W-1:0] reg_rdata,
    input logic             req_valid,
    input logic [XA_W-1:0]  req_addr,
    input logic             rsp_valid,
    input logic [1:0]       rsp_kind,
    input logic [XA_W-1:0]  rsp_addr,
    input logic [XA_W-1:0]  rsp_mask,
    input logic             ctl_hole
);

    AST_RSP_AFTER_REQ: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> rsp_valid);                                        // R5
    AST_RSP_IDLE: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> !rsp_valid);                                      // R5
    AST_HOLE_MISS: assert property (@(posedge clk) disable iff (rst)
        (req_valid && ctl_hole && req_addr >= HOLE_LO && req_addr <= HOLE_HI)
        |=> (rsp_kind == 2'd0));                                         // R10
    AST_FLAT_SHAPE: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_kind == 2'd3) |-> (rsp_addr == '0 && rsp_mask == FLAT_MASK)); // R11
    AST_SAC_NOT_FLAT: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_addr[XA_W-1:SAC_W] == '0) |=> (rsp_kind != 2'd3)); // R11
    AST_MISS_ZERO: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_kind == 2'd0) |-> (rsp_addr == '0 && rsp_mask == '0)); // R13
    AST_DIRECT_ALIGNED: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_kind == 2'd1)
        |-> (rsp_mask[19:0] == 20'hFFFFF && (rsp_addr & rsp_mask) == '0)); // R7
    AST_WIN3_SG_READ: assert property (@(posedge clk) disable iff (rst)
        (reg_addr == 10'h0C0) |-> reg_rdata[WIN_SG_BIT]);                // R3

endmodule

bind dma_xlat dma_xlat_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .reg_addr  (reg_addr),
    .reg_rdata (reg_rdata),
    .req_valid (req_valid),
    .req_addr  (req_addr),
    .rsp_valid (rsp_valid),
    .rsp_kind  (rsp_kind),
    .rsp_addr  (rsp_addr),
    .rsp_mask  (rsp_mask),
    .ctl_hole  (ctl_hole)
);

// File: tb/dma_xlat_bench.sv
`timescale 1ns/1ps
module dma_xlat_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_we = 1'b0;
    logic [9:0]  reg_addr = '0;
    logic [63:0] reg_wdata = '0;
    logic [63:0] reg_rdata;
    logic        req_valid = 1'b0;
    logic [43:0] req_addr = '0;
    logic        rsp_valid;
    logic [1:0]  rsp_kind;
    logic [43:0] rsp_addr;
    logic [43:0] rsp_mask;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    dma_xlat u_dma_xlat (
        .clk, .rst, .reg_we, .reg_addr, .reg_wdata, .reg_rdata,
        .req_valid, .req_addr, .rsp_valid, .rsp_kind, .rsp_addr, .rsp_mask
    );

    typedef struct packed {
        logic        op;     // 0 register write, 1 translate
        logic [63:0] a;      // offset or bus address
        logic [63:0] d;      // write data
        logic [1:0]  kind;
        logic [63:0] pa;
        logic [63:0] mk;
        logic [7:0]  req;
    } step_t;

    localparam int NSTEP = 32;
    localparam step_t STEPS [NSTEP] = '{
        '{1'b0, 64'h000, 64'h0010_0001,     2'd0, 64'h0, 64'h0, 8'd2},  // R2 win0 direct
        '{1'b0, 64'h200, 64'h4000_0000,     2'd0, 64'h0, 64'h0, 8'd4},
        '{1'b0, 64'h080, 64'h0000_0001,     2'd0, 64'h0, 64'h0, 8'd2},  // win2 direct
        '{1'b0, 64'h180, 64'h0010_0000,     2'd0, 64'h0, 64'h0, 8'd4},
        '{1'b0, 64'h280, 64'h3_1234_5C00,   2'd0, 64'h0, 64'h0, 8'd4},
        '{1'b0, 64'h040, 64'h4000_0003,     2'd0, 64'h0, 64'h0, 8'd2},  // win1 sg
        '{1'b0, 64'h140, 64'h00F0_0000,     2'd0, 64'h0, 64'h0, 8'd4},
        '{1'b0, 64'h240, 64'h2_0000_0000,   2'd0, 64'h0, 64'h0, 8'd4},
        '{1'b0, 64'h0C0, 64'h8000_0001,     2'd0, 64'h0, 64'h0, 8'd3},  // R3 win3 sac
        '{1'b0, 64'h2C0, 64'h5_0000_0000,   2'd0, 64'h0, 64'h0, 8'd4},
        '{1'b1, 64'h0015_0000, 64'h0, 2'd1, 64'h4000_0000,   64'hF_FFFF,  8'd9},  // R9 win0 over win2
        '{1'b1, 64'h0005_0000, 64'h0, 2'd1, 64'h3_1220_0000, 64'h1F_FFFF, 8'd7},  // R7
        '{1'b1, 64'h0009_0000, 64'h0, 2'd1, 64'h3_1220_0000, 64'h1F_FFFF, 8'd10}, // R10 hole off
        '{1'b1, 64'h4012_3456, 64'h0, 2'd2, 64'h2_0000_0488, 64'h0,       8'd8},  // R8
        '{1'b1, 64'h8001_2000, 64'h0, 2'd2, 64'h5_0000_0048, 64'h0,       8'd9},  // R9 win3 sac
        '{1'b1, 64'h2000_0000, 64'h0, 2'd0, 64'h0,           64'h0,       8'd6},  // R6
        '{1'b1, 64'h4100_0000, 64'h0, 2'd0, 64'h0,           64'h0,       8'd6},  // R6 past win1
        '{1'b0, 64'h300, 64'h20,            2'd0, 64'h0, 64'h0, 8'd4},
        '{1'b1, 64'h0009_0000, 64'h0, 2'd0, 64'h0,           64'h0,       8'd10}, // R10
        '{1'b1, 64'h0007_FFFF, 64'h0, 2'd1, 64'h3_1220_0000, 64'h1F_FFFF, 8'd10},
        '{1'b1, 64'h000F_FFFF, 64'h0, 2'd0, 64'h0,           64'h0,       8'd10},
        '{1'b1, 64'h0010_0000, 64'h0, 2'd1, 64'h4000_0000,   64'hF_FFFF,  8'd10},
        '{1'b1, 64'h100_0000_0000, 64'h0, 2'd0, 64'h0,       64'h0,       8'd11}, // R11 flat off
        '{1'b0, 64'h300, 64'h60,            2'd0, 64'h0, 64'h0, 8'd4},
        '{1'b1, 64'h1AB_CDEF_0123, 64'h0, 2'd3, 64'h0,       64'h7_FFFF_FFFF, 8'd11},
        '{1'b1, 64'h1FF_FFFF_FFFF, 64'h0, 2'd3, 64'h0,       64'h7_FFFF_FFFF, 8'd11},
        '{1'b0, 64'h0C0, 64'h100_8000_0001, 2'd0, 64'h0, 64'h0, 8'd3},
        '{1'b1, 64'h8001_2000, 64'h0, 2'd0, 64'h0,           64'h0,       8'd9},  // win3 dac only
        '{1'b1, 64'h800_1234_6000, 64'h0, 2'd2, 64'h5_0004_8D18, 64'h0,   8'd12}, // R12
        '{1'b1, 64'h400_0000_0000, 64'h0, 2'd0, 64'h0,       64'h0,       8'd13}, // R13
        '{1'b0, 64'h000, 64'h0010_0000,     2'd0, 64'h0, 64'h0, 8'd2},  // disable win0
        '{1'b1, 64'h0015_0000, 64'h0, 2'd1, 64'h3_1220_0000, 64'h1F_FFFF, 8'd2}
    };

    task automatic check(input int req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL R%0d %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic wr(input logic [9:0] ofs, input logic [63:0] val);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = ofs; reg_wdata = val;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd_chk(input logic [9:0] ofs, input logic [63:0] exp, input int req);
        @(negedge clk);
        reg_addr = ofs;
        #2;
        check(req, $sformatf("read %h", ofs), reg_rdata, exp);
    endtask

    task automatic xlat(input step_t s);
        @(negedge clk);
        req_valid = 1'b1; req_addr = s.a[43:0];
        @(negedge clk);
        req_valid = 1'b0;
        check(5, "rsp_valid", {63'd0, rsp_valid}, 64'd1);
        check(int'(s.req), $sformatf("kind @%h", s.a), {62'd0, rsp_kind}, {62'd0, s.kind});
        check(int'(s.req), $sformatf("addr @%h", s.a), {20'd0, rsp_addr}, s.pa);
        check(int'(s.req), $sformatf("mask @%h", s.a), {20'd0, rsp_mask}, s.mk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // reset state: R5 idle, R3 reset value, R1/R4 zero
        check(5, "reset rsp_valid", {63'd0, rsp_valid}, 64'd0);
        rd_chk(10'h0C0, 64'h2, 3);
        rd_chk(10'h000, 64'h0, 4);
        rd_chk(10'h300, 64'h0, 4);

        for (int i = 0; i < NSTEP; i++) begin
            if (STEPS[i].op)
                xlat(STEPS[i]);
            else
                wr(STEPS[i].a[9:0], STEPS[i].d);
        end

        @(negedge clk);
        check(5, "idle rsp_valid", {63'd0, rsp_valid}, 64'd0);

        // write masking, directed
        rd_chk(10'h300, 64'h60, 4);
        wr(10'h000, '1);  rd_chk(10'h000, 64'hFFF0_0003, 2);
        wr(10'h0C0, '1);  rd_chk(10'h0C0, 64'h100_FFF0_0003, 3);
        wr(10'h140, '1);  rd_chk(10'h140, 64'hFFF0_0000, 4);
        wr(10'h240, '1);  rd_chk(10'h240, 64'h7_FFFF_FC00, 4);
        wr(10'h300, '1);  rd_chk(10'h300, 64'h0000_1CFF_0FC7_FF, 4);
        // unmapped offsets: R1
        wr(10'h004, 64'h0);
        rd_chk(10'h004, 64'h0, 1);
        rd_chk(10'h000, 64'hFFF0_0003, 1);
        wr(10'h340, '1);
        rd_chk(10'h340, 64'h0, 1);
        rd_chk(10'h300, 64'h0000_1CFF_0FC7_FF, 1);
        wr(10'h0C0, 64'h0); rd_chk(10'h0C0, 64'h2, 3);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule